// File: doc/BRIEF.md
# Translation Table Base Address Former

This block turns a 64-bit translation base register into the values a first-level table walker needs. Its inputs are the register word, the physical-address-size control, the granule size, a few implementation feature flags and the alignment bit index `x`, which is computed elsewhere. Its outputs are the physical base address of the first-level table (up to 52 bits), the effective ASID, the common-not-private flag, and three diagnostics: an address-size fault, a misalignment warning and an illegal-configuration flag.

The register word has a fixed layout. The ASID sits in bits [63:48]. The base address field sits in bits [47:1], and bit 0 carries the common-not-private flag. The top four address bits [51:48] are taken from register bits [5:2], but only in the legal 52-bit mode. That mode also decides which low register bits are reserved and therefore able to raise the misalignment warning. The logic is combinational. The `REG_OUT` parameter adds one output register stage, and it defaults to on.

Top module: `tbase_former`

## Requirements
- R1: When `asidWide` is 1, `asidOut` equals register bits [63:48]. When it is 0, `asidOut` is {8'h00, register bits [55:48]}.
- R2: `commonFlag` equals register bit 0 when `featCnp` is 1, and it is 0 otherwise.
- R3: With `e` as the effective alignment index, `tableBase[i]` equals register bit i for e <= i <= 47, and `tableBase[i]` is 0 for every i below e.
- R4: Whenever the block is not in legal 52-bit mode, `tableBase[51:48]` is 0. This covers `sizeCtl` other than 3'b110, and 3'b110 with an illegal granule.
- R5: Granule codes are 0 = 4KB, 1 = 16KB, 2 = 64KB and 3 = reserved. With `sizeCtl` = 3'b110, the mode is legal when either of two conditions holds:
  - `featLpa` is 1 and the granule code is 2;
  - `featLpa2` is 1 and the granule code is 0 or 1.

  In legal 52-bit mode, `tableBase[51:48]` equals register bits [5:2].
- R6: `illegalCfg` is 1 exactly when `sizeCtl` is 3'b110 and the mode is not legal.
- R7: `sizeFault` is 1 exactly when all three of these hold:
  - `paRange52` is 0;
  - `sizeCtl` is 3'b110, whether or not the granule is legal;
  - register bits [5:2] are nonzero.
- R8: Outside legal 52-bit mode, `misalignWarn` is 1 exactly when some register bit in [e-1:1] is 1.
- R9: In legal 52-bit mode, `misalignWarn` is 1 exactly when register bit 1 is 1, or some bit in [e-1:6] is 1. Bits [5:2] never raise it in this mode.
- R10: With `REG_OUT` = 1, every output appears one clock edge after its inputs. While `rstN` is low, all outputs are 0.
- R11: The effective alignment index `e` is `alignIdx` clamped to the range 6..47. Values below 6 act as 6, and values above 47 act as 47.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rstN | input | 1 | Asynchronous active-low reset of the output stage |
| baseReg | input | 64 | Translation base register word |
| sizeCtl | input | 3 | Physical-address-size control; 3'b110 requests 52-bit mode |
| granule | input | 2 | Granule code: 0 = 4KB, 1 = 16KB, 2 = 64KB, 3 = reserved |
| featLpa | input | 1 | Large-PA feature present (64KB granule) |
| featLpa2 | input | 1 | Extended large-PA feature present (4KB and 16KB granules) |
| featCnp | input | 1 | Common-not-private feature present |
| asidWide | input | 1 | 1 selects a 16-bit ASID, 0 selects an 8-bit ASID |
| paRange52 | input | 1 | Implemented PA range reaches 52 bits |
| alignIdx | input | 6 | Alignment bit index x |
| tableBase | output | 52 | First-level table physical base address |
| asidOut | output | 16 | Effective ASID |
| commonFlag | output | 1 | Effective common-not-private flag |
| sizeFault | output | 1 | Address-size fault indication |
| misalignWarn | output | 1 | A reserved base-field bit is set |
| illegalCfg | output | 1 | 52-bit request with an unsupported granule or feature combination |

## Verification
The bound checker compares each cycle's outputs with the inputs sampled one edge earlier. On every cycle it checks the following:
- the fault condition;
- zero upper address bits outside the 52-bit request, and whenever `illegalCfg` is set;
- zero address bits below the clamped index;
- suppression of the flag when its feature is absent;
- the narrow-ASID upper byte being zero.

Some behaviours are shown only by the bench scenarios:
- which reserved bits raise the warning in each mode;
- the exact bits [5:2] carried into the top of the address;
- the legality matrix of granule against feature flags;
- the reset values and the one-cycle latency.

// File: rtl/tbaf_pkg.sv
package tbaf_pkg;

  typedef enum logic [1:0] {
    GRAN_4K   = 2'd0,
    GRAN_16K  = 2'd1,
    GRAN_64K  = 2'd2,
    GRAN_RSVD = 2'd3
  } granule_e;

  localparam logic [2:0] SIZE_WIDE = 3'b110;
  localparam int unsigned ALIGN_MIN = 6;
  localparam int unsigned ALIGN_MAX = 47;

  // strobes from control to datapath
  typedef struct packed {
    logic       wideMode;
    logic       illegalCfg;
    logic       sizeFault;
    logic       asidWide;
    logic       cnpEnable;
    logic [5:0] alignEff;
  } ctrlStrobe_t;

  function automatic logic [5:0] clampAlign(input logic [5:0] raw);
    if (raw < 6'(ALIGN_MIN))      return 6'(ALIGN_MIN);
    else if (raw > 6'(ALIGN_MAX)) return 6'(ALIGN_MAX);
    else                          return raw;
  endfunction

endpackage

// File: rtl/tbaf_ctrl.sv
module tbaf_ctrl
  import tbaf_pkg::*;
(
  input  logic [2:0]  sizeCtl,
  input  logic [1:0]  granule,
  input  logic        featLpa,
  input  logic        featLpa2,
  input  logic        featCnp,
  input  logic        asidWide,
  input  logic        paRange52,
  input  logic [5:0]  alignIdx,
  input  logic [3:0]  hiField,
  output ctrlStrobe_t strobes
);

  granule_e granKind;
  logic     wideReq;
  logic     wideLegal;

  always_comb begin
    granKind  = granule_e'(granule);
    wideReq   = (sizeCtl == SIZE_WIDE);
    wideLegal = 1'b0;
    unique case (granKind)
      GRAN_64K:           wideLegal = featLpa;
      GRAN_4K, GRAN_16K:  wideLegal = featLpa2;
      default:            wideLegal = 1'b0;
    endcase
  end

  always_comb begin
    strobes.wideMode   = wideReq && wideLegal;
    strobes.illegalCfg = wideReq && !wideLegal;
    strobes.sizeFault  = wideReq && !paRange52 && (hiField != 4'd0);
    strobes.asidWide   = asidWide;
    strobes.cnpEnable  = featCnp;
    strobes.alignEff   = clampAlign(alignIdx);
  end

endmodule

// File: rtl/tbaf_datapath.sv
module tbaf_datapath
  import tbaf_pkg::*;
#(
  parameter int unsigned PA_BITS     = 52,
  parameter int unsigned ASID_BITS   = 16,
  parameter int unsigned ASID_NARROW = 8
) (
  input  logic [63:0]          baseReg,
  input  ctrlStrobe_t          strobes,
  output logic [PA_BITS-1:0]   tableBase,
  output logic [ASID_BITS-1:0] asidOut,
  output logic                 commonFlag,
  output logic                 misalignWarn
);

  localparam int unsigned FIELD_TOP = 47;
  localparam int unsigned HI_W      = PA_BITS - FIELD_TOP - 1;
  localparam int unsigned HI_LO     = 2;
  localparam int unsigned ASID_LO   = 48;
  localparam int unsigned PAD_W     = ASID_BITS - ASID_NARROW;

  logic [FIELD_TOP:0] lowPart;
  logic [FIELD_TOP:0] resvHit;

  for (genvar i = 0; i <= FIELD_TOP; i++) begin : g_bit
    logic belowAlign;
    assign belowAlign = (6'(i) < strobes.alignEff);
    assign lowPart[i] = baseReg[i] & ~belowAlign;
    if (i == 0) begin : g_flag
      assign resvHit[i] = 1'b0;
    end else if (i >= HI_LO && i < HI_LO + HI_W) begin : g_hi
      // carries upper address bits in wide mode
      assign resvHit[i] = baseReg[i] & belowAlign & ~strobes.wideMode;
    end else begin : g_plain
      assign resvHit[i] = baseReg[i] & belowAlign;
    end
  end

  always_comb begin
    tableBase = {(strobes.wideMode ? baseReg[HI_LO+HI_W-1:HI_LO] : HI_W'(0)), lowPart};
    if (strobes.asidWide)
      asidOut = baseReg[ASID_LO+ASID_BITS-1:ASID_LO];
    else
      asidOut = {PAD_W'(0), baseReg[ASID_LO+ASID_NARROW-1:ASID_LO]};
    commonFlag   = strobes.cnpEnable & baseReg[0];
    misalignWarn = |resvHit;
  end

endmodule

// File: rtl/tbase_former.sv
module tbase_former
  import tbaf_pkg::*;
#(
  parameter int unsigned PA_BITS   = 52,
  parameter int unsigned ASID_BITS = 16,
  parameter bit          REG_OUT   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [63:0]          baseReg,
  input  logic [2:0]           sizeCtl,
  input  logic [1:0]           granule,
  input  logic                 featLpa,
  input  logic                 featLpa2,
  input  logic                 featCnp,
  input  logic                 asidWide,
  input  logic                 paRange52,
  input  logic [5:0]           alignIdx,
  output logic [PA_BITS-1:0]   tableBase,
  output logic [ASID_BITS-1:0] asidOut,
  output logic                 commonFlag,
  output logic                 sizeFault,
  output logic                 misalignWarn,
  output logic                 illegalCfg
);

  ctrlStrobe_t            strobes;
  logic [PA_BITS-1:0]     baseNext;
  logic [ASID_BITS-1:0]   asidNext;
  logic                   cnpNext;
  logic                   warnNext;

  tbaf_ctrl u_ctrl (
    .sizeCtl   (sizeCtl),
    .granule   (granule),
    .featLpa   (featLpa),
    .featLpa2  (featLpa2),
    .featCnp   (featCnp),
    .asidWide  (asidWide),
    .paRange52 (paRange52),
    .alignIdx  (alignIdx),
    .hiField   (baseReg[5:2]),
    .strobes   (strobes)
  );

  tbaf_datapath #(
    .PA_BITS   (PA_BITS),
    .ASID_BITS (ASID_BITS)
  ) u_dp (
    .baseReg      (baseReg),
    .strobes      (strobes),
    .tableBase    (baseNext),
    .asidOut      (asidNext),
    .commonFlag   (cnpNext),
    .misalignWarn (warnNext)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tableBase    <= '0;
        asidOut      <= '0;
        commonFlag   <= 1'b0;
        sizeFault    <= 1'b0;
        misalignWarn <= 1'b0;
        illegalCfg   <= 1'b0;
      end else begin
        tableBase    <= baseNext;
        asidOut      <= asidNext;
        commonFlag   <= cnpNext;
        sizeFault    <= strobes.sizeFault;
        misalignWarn <= warnNext;
        illegalCfg   <= strobes.illegalCfg;
      end
    end
  end else begin : g_comb
    assign tableBase    = baseNext;
    assign asidOut      = asidNext;
    assign commonFlag   = cnpNext;
    assign sizeFault    = strobes.sizeFault;
    assign misalignWarn = warnNext;
    assign illegalCfg   = strobes.illegalCfg;
  end

endmodule

// File: rtl/tbase_former_chk.sv
module tbase_former_chk
  import tbaf_pkg::*;
#(
  parameter int unsigned PA_BITS   = 52,
  parameter int unsigned ASID_BITS = 16,
  parameter bit          REG_OUT   = 1'b1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [3:0]           hiField,
  input logic [2:0]           sizeCtl,
  input logic                 featCnp,
  input logic                 asidWide,
  input logic                 paRange52,
  input logic [5:0]           alignIdx,
  input logic [PA_BITS-1:0]   tableBase,
  input logic [ASID_BITS-1:0] asidOut,
  input logic                 commonFlag,
  input logic                 sizeFault,
  input logic                 illegalCfg
);

  localparam int unsigned HI_LSB = 48;

  function automatic logic [47:0] maskBelow(input logic [5:0] e);
    logic [47:0] m;
    for (int i = 0; i < 48; i++) m[i] = (6'(i) < e);
    return m;
  endfunction

  if (REG_OUT) begin : g_seq
    p_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> sizeFault == (!$past(paRange52) && ($past(sizeCtl) == SIZE_WIDE)
                                   && ($past(hiField) != 4'd0)));

    p_hi_narrow_r4: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && ($past(sizeCtl) != SIZE_WIDE)) |-> (tableBase[PA_BITS-1:HI_LSB] == '0));

    p_align_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> ((tableBase[47:0] & maskBelow(clampAlign($past(alignIdx)))) == 48'd0));

    p_cnp_off_r2: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !$past(featCnp)) |-> !commonFlag);

    p_asid_narrow_r1: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !$past(asidWide)) |-> (asidOut[ASID_BITS-1:8] == '0));
  end

  p_illegal_hi_r6: assert property (@(posedge clk) disable iff (!rstN)
    illegalCfg |-> (tableBase[PA_BITS-1:HI_LSB] == '0));

endmodule

bind tbase_former tbase_former_chk #(
  .PA_BITS   (PA_BITS),
  .ASID_BITS (ASID_BITS),
  .REG_OUT   (REG_OUT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hiField    (baseReg[5:2]),
  .sizeCtl    (sizeCtl),
  .featCnp    (featCnp),
  .asidWide   (asidWide),
  .paRange52  (paRange52),
  .alignIdx   (alignIdx),
  .tableBase  (tableBase),
  .asidOut    (asidOut),
  .commonFlag (commonFlag),
  .sizeFault  (sizeFault),
  .illegalCfg (illegalCfg)
);

// File: tb/tb_tbase_former.sv
`timescale 1ns/1ps
module tb_tbase_former;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] baseReg = '0;
  logic [2:0]  sizeCtl = '0;
  logic [1:0]  granule = '0;
  logic        featLpa = 0, featLpa2 = 0, featCnp = 0, asidWide = 0, paRange52 = 0;
  logic [5:0]  alignIdx = '0;
  logic [51:0] tableBase;
  logic [15:0] asidOut;
  logic        commonFlag, sizeFault, misalignWarn, illegalCfg;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  tbase_former dut (
    .clk(clk), .rstN(rstN), .baseReg(baseReg), .sizeCtl(sizeCtl), .granule(granule),
    .featLpa(featLpa), .featLpa2(featLpa2), .featCnp(featCnp), .asidWide(asidWide),
    .paRange52(paRange52), .alignIdx(alignIdx), .tableBase(tableBase), .asidOut(asidOut),
    .commonFlag(commonFlag), .sizeFault(sizeFault), .misalignWarn(misalignWarn),
    .illegalCfg(illegalCfg)
  );

  typedef struct packed {
    logic [63:0] tag;
    logic [63:0] r;
    logic [2:0]  sz;
    logic [1:0]  g;
    logic        lpa, lpa2, cnpF, aw, pa52;
    logic [5:0]  x;
    logic [51:0] eBase;
    logic [15:0] eAsid;
    logic        eCnp, eFault, eWarn, eIll;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{"R3R4",   64'hABCD_0000_1234_5001, 3'b101, 2'd0, 1'b0,1'b0,1'b1,1'b1,1'b1, 6'd12, 52'h0_0000_1234_5000, 16'hABCD, 1'b1,1'b0,1'b0,1'b0},
    '{"R1R2",   64'hABCD_0000_1234_5001, 3'b101, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b1, 6'd12, 52'h0_0000_1234_5000, 16'h00CD, 1'b0,1'b0,1'b0,1'b0},
    '{"R5",     64'h0001_0000_0001_003C, 3'b110, 2'd2, 1'b1,1'b0,1'b1,1'b1,1'b1, 6'd16, 52'hF_0000_0001_0000, 16'h0001, 1'b0,1'b0,1'b0,1'b0},
    '{"R7",     64'h0001_0000_0001_003C, 3'b110, 2'd2, 1'b1,1'b0,1'b1,1'b1,1'b0, 6'd16, 52'hF_0000_0001_0000, 16'h0001, 1'b0,1'b1,1'b0,1'b0},
    '{"R6R8",   64'h0001_0000_0001_003C, 3'b110, 2'd2, 1'b0,1'b1,1'b1,1'b1,1'b1, 6'd16, 52'h0_0000_0001_0000, 16'h0001, 1'b0,1'b0,1'b1,1'b1},
    '{"R5R9",   64'h0000_0000_0000_0044, 3'b110, 2'd0, 1'b0,1'b1,1'b1,1'b1,1'b1, 6'd7,  52'h1_0000_0000_0000, 16'h0000, 1'b0,1'b0,1'b1,1'b0},
    '{"R9",     64'h0000_0000_8000_0024, 3'b110, 2'd2, 1'b1,1'b0,1'b1,1'b1,1'b1, 6'd6,  52'h9_0000_8000_0000, 16'h0000, 1'b0,1'b0,1'b0,1'b0},
    '{"R8",     64'h0000_0000_8000_0024, 3'b000, 2'd2, 1'b1,1'b0,1'b1,1'b1,1'b1, 6'd6,  52'h0_0000_8000_0000, 16'h0000, 1'b0,1'b0,1'b1,1'b0},
    '{"R11",    64'h0000_0000_0000_0FC0, 3'b010, 2'd0, 1'b0,1'b0,1'b0,1'b1,1'b1, 6'd0,  52'h0_0000_0000_0FC0, 16'h0000, 1'b0,1'b0,1'b0,1'b0},
    '{"R11",    64'h0000_FFFF_FFFF_FFFE, 3'b101, 2'd0, 1'b0,1'b0,1'b0,1'b1,1'b1, 6'd63, 52'h0_8000_0000_0000, 16'h0000, 1'b0,1'b0,1'b1,1'b0},
    '{"R7",     64'h0000_0000_0001_0000, 3'b110, 2'd2, 1'b1,1'b0,1'b0,1'b1,1'b0, 6'd16, 52'h0_0000_0001_0000, 16'h0000, 1'b0,1'b0,1'b0,1'b0},
    '{"R6R7",   64'h0000_0000_0000_0004, 3'b110, 2'd0, 1'b0,1'b0,1'b0,1'b1,1'b0, 6'd6,  52'h0_0000_0000_0000, 16'h0000, 1'b0,1'b1,1'b1,1'b1},
    '{"R6",     64'h0000_0000_0000_003C, 3'b110, 2'd3, 1'b1,1'b1,1'b0,1'b1,1'b1, 6'd6,  52'h0_0000_0000_0000, 16'h0000, 1'b0,1'b0,1'b1,1'b1}
  };

  task automatic applyVec(input vec_t v);
    baseReg = v.r; sizeCtl = v.sz; granule = v.g; featLpa = v.lpa; featLpa2 = v.lpa2;
    featCnp = v.cnpF; asidWide = v.aw; paRange52 = v.pa52; alignIdx = v.x;
  endtask

  task automatic checkVec(input vec_t v);
    logic [71:0] act, exp;
    act = {tableBase, asidOut, commonFlag, sizeFault, misalignWarn, illegalCfg};
    exp = {v.eBase, v.eAsid, v.eCnp, v.eFault, v.eWarn, v.eIll};
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual base=%h asid=%h cnp=%b flt=%b warn=%b ill=%b expected base=%h asid=%h cnp=%b flt=%b warn=%b ill=%b",
               v.tag, tableBase, asidOut, commonFlag, sizeFault, misalignWarn, illegalCfg,
               v.eBase, v.eAsid, v.eCnp, v.eFault, v.eWarn, v.eIll);
    end
  endtask

  task automatic checkVal(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    // R10: reset holds outputs at zero even with live inputs
    applyVec(VECS[0]);
    repeat (3) @(negedge clk);
    checkVal("R10 reset", {tableBase, asidOut, commonFlag, sizeFault, misalignWarn, illegalCfg}, 72'd0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      applyVec(VECS[k]);
      @(negedge clk);
      checkVec(VECS[k]);
    end

    // R10: new input not visible before the next edge
    @(negedge clk);
    applyVec(VECS[9]);
    #1;
    checkVal("R10 hold", 72'(tableBase), 72'(VECS[NV-1].eBase));
    @(negedge clk);
    checkVal("R10 latency", 72'(tableBase), 72'(VECS[9].eBase));

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule